// File: doc/BRIEF.md
# Text-Mode Character Video Serializer

This block converts one character cell of a text display into a serial pixel stream. Each pixel clock, it captures a character byte and a 4-bit scan-line number. The low seven bits of the byte, the line number and a set-select bit address a glyph memory. That memory holds a standard and an alternate set of 128 characters. The 8-bit pixel row it returns is parallel-loaded into a shift register on a load pulse and then leaves the block one pixel per clock as the video bit.

Two attributes are applied at load time:
- **Null blanking.** The null character (code 0) can be blanked, depending on a display-null option.
- **Dimming.** The top bit of the character byte marks a protected character. It drives a dim output for the eight pixels of that cell.

The glyph memory is filled through a synchronous write port. Sync generation and video mixing are left to other blocks.

Top module: `txvSerializer`

## Requirements
- R1: The glyph memory address is formed from `altSet` (most significant), `charByte[6:0]` and `lineNum` (least significant). The row read for the inputs of one cycle is the row that a load pulse in the next cycle transfers.
- R2: With `altSet` = 0 the standard set (set 0) is read. With `altSet` = 1 the alternate set (set 1) is read, and the two sets hold independent contents.
- R3: On a clock edge with `loadPulse` = 1, the shift register takes the looked-up 8-bit row. `videoBit` shows bit 7 of that row in the following cycle.
- R4: On every edge without `loadPulse`, the shift register moves one place towards the MSB with a 0 entering at bit 0. Pixels therefore leave MSB first, and `videoBit` is 0 once eight shifts have passed since the last load.
- R5: When `showNull` = 0 at the load edge and the captured code bits [6:0] are all zero, the loaded row is all zeros.
- R6: When `showNull` = 1 at the load edge, code 0 loads its stored glyph row like any other code.
- R7: `dimOut` takes bit 7 of the captured character byte at each load edge and holds that value until the next load edge.
- R8: Bit 7 of `charByte` does not take part in the glyph address. Codes that differ only in bit 7 produce the same pixels.
- R9: After reset, `videoBit` and `dimOut` are 0 and remain 0 until the first load.
- R10: A write with `glyphWrEn` = 1 stores `glyphWrData` at address {`glyphWrSet`, `glyphWrCode`, `glyphWrLine`} at the clock edge. A later lookup of that address returns the new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| charByte | input | 8 | Character byte; bits [6:0] code, bit 7 protect |
| lineNum | input | 4 | Scan line within the character row |
| altSet | input | 1 | Glyph set select, 0 = standard |
| showNull | input | 1 | 1 = display code 0, 0 = blank it |
| loadPulse | input | 1 | Parallel load of the shift register |
| glyphWrEn | input | 1 | Glyph memory write enable |
| glyphWrSet | input | 1 | Set of the glyph write |
| glyphWrCode | input | 7 | Code of the glyph write |
| glyphWrLine | input | 4 | Line of the glyph write |
| glyphWrData | input | 8 | Pixel row to store |
| videoBit | output | 1 | Serial pixel, MSB of the shift register |
| dimOut | output | 1 | Reduced-intensity flag of the cell on screen |

## Verification
**Corrupted shift register.** A wrong bit in the shift register reaches `videoBit` within at most seven cycles, as it walks towards the MSB. A wrong fill bit shows as a stray lit pixel late in the cell.

**Wrong dim state or lookup.** A wrong dim register shows on `dimOut` at once and stays wrong for the whole eight-pixel cell. A wrong captured code or glyph row becomes visible in the first cycle after the next load.

**Comparison method.** The bench compares both outputs against a reference model on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/txv_pkg.sv
package txv_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // parallel load of pixel row
    logic shift;  // advance one pixel
  } txvStrobe_t;
endpackage

// File: rtl/txvControl.sv
module txvControl #(
  parameter int PIX_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         loadPulse,
  output txv_pkg::txvStrobe_t          strb,
  output logic [$clog2(PIX_W+1)-1:0]   shiftCnt
);
  localparam int CNT_W = $clog2(PIX_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PIX_W);

  always_comb begin
    strb.load  = loadPulse;
    strb.shift = !loadPulse;
  end

  // counts shifts since the last load, saturating at PIX_W
  always_ff @(posedge clk) begin
    if (!rstN)               shiftCnt <= CNT_MAX;
    else if (strb.load)      shiftCnt <= '0;
    else if (shiftCnt != CNT_MAX) shiftCnt <= shiftCnt + 1'b1;
  end

  // R4: counter never passes the row width
  a_r4_cnt_cap: assert property (@(posedge clk) disable iff (!rstN)
    shiftCnt <= CNT_MAX);
  // R3: a load always restarts the count
  a_r3_load_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> shiftCnt == '0);
endmodule

// File: rtl/txvDatapath.sv
module txvDatapath #(
  parameter int CODE_W = 7,
  parameter int LINE_W = 4,
  parameter int PIX_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  txv_pkg::txvStrobe_t   strb,
  input  logic [CODE_W:0]       charByte,
  input  logic [LINE_W-1:0]     lineNum,
  input  logic                  altSet,
  input  logic                  showNull,
  input  logic                  glyphWrEn,
  input  logic                  glyphWrSet,
  input  logic [CODE_W-1:0]     glyphWrCode,
  input  logic [LINE_W-1:0]     glyphWrLine,
  input  logic [PIX_W-1:0]      glyphWrData,
  output logic                  videoBit,
  output logic                  dimOut
);
  localparam int ADDR_W = 1 + CODE_W + LINE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [PIX_W-1:0]  glyphMem [DEPTH];
  logic [CODE_W:0]   charReg;
  logic [CODE_W:0]   charInv;
  logic [PIX_W-1:0]  glyphRow;
  logic [PIX_W-1:0]  shiftReg;
  logic              dimReg;
  logic              nullCode;
  logic              blankNow;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;

  assign rdAddr = {altSet, charByte[CODE_W-1:0], lineNum};
  assign wrAddr = {glyphWrSet, glyphWrCode, glyphWrLine};

  // glyph memory: synchronous read and write, no reset
  always_ff @(posedge clk) begin
    glyphRow <= glyphMem[rdAddr];
    if (glyphWrEn) glyphMem[wrAddr] <= glyphWrData;
  end

  // character latch, captured every pixel clock
  always_ff @(posedge clk) begin
    if (!rstN) charReg <= '0;
    else       charReg <= charByte;
  end

  // inverted form feeds the null decode
  assign charInv  = ~charReg;
  assign nullCode = &charInv[CODE_W-1:0];
  assign blankNow = nullCode && !showNull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dimReg   <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= blankNow ? '0 : glyphRow;
      dimReg   <= charReg[CODE_W];
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[PIX_W-2:0], 1'b0};
    end
  end

  assign videoBit = shiftReg[PIX_W-1];
  assign dimOut   = dimReg;

  // R4: the fill bit is always zero after a shift
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> shiftReg[0] == 1'b0);
  // R7: attribute holds between loads
  a_r7_dim_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dimReg));
  // R5: blanked null loads an empty row
  a_r5_null_blank: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && nullCode && !showNull) |=> shiftReg == '0);
  // R3: a non-blanked load copies the looked-up row
  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !blankNow) |=> shiftReg == $past(glyphRow));
endmodule

// File: rtl/txvSerializer.sv
module txvSerializer #(
  parameter int CODE_W = 7,
  parameter int LINE_W = 4,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        charByte,
  input  logic [3:0]        lineNum,
  input  logic              altSet,
  input  logic              showNull,
  input  logic              loadPulse,
  input  logic              glyphWrEn,
  input  logic              glyphWrSet,
  input  logic [6:0]        glyphWrCode,
  input  logic [3:0]        glyphWrLine,
  input  logic [7:0]        glyphWrData,
  output logic              videoBit,
  output logic              dimOut
);
  localparam int CNT_W = $clog2(PIX_W + 1);

  txv_pkg::txvStrobe_t strb;
  logic [CNT_W-1:0]    shiftCnt;

  txvControl #(.PIX_W(PIX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .loadPulse(loadPulse),
    .strb(strb), .shiftCnt(shiftCnt)
  );

  txvDatapath #(.CODE_W(CODE_W), .LINE_W(LINE_W), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .charByte(charByte), .lineNum(lineNum), .altSet(altSet),
    .showNull(showNull),
    .glyphWrEn(glyphWrEn), .glyphWrSet(glyphWrSet),
    .glyphWrCode(glyphWrCode), .glyphWrLine(glyphWrLine),
    .glyphWrData(glyphWrData),
    .videoBit(videoBit), .dimOut(dimOut)
  );

  // R4: once the row is fully shifted out the screen is dark
  a_r4_drained_dark: assert property (@(posedge clk) disable iff (!rstN)
    (shiftCnt == CNT_W'(PIX_W)) |-> !videoBit);
endmodule

// File: tb/sim_txvSerializer.sv
module sim_txvSerializer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] charByte = '0;
  logic [3:0] lineNum = '0;
  logic altSet = 1'b0, showNull = 1'b0, loadPulse = 1'b0;
  logic glyphWrEn = 1'b0, glyphWrSet = 1'b0;
  logic [6:0] glyphWrCode = '0;
  logic [3:0] glyphWrLine = '0;
  logic [7:0] glyphWrData = '0;
  logic videoBit, dimOut;

  int total = 0, bad = 0;
  bit done = 0;
  string curReq = "R9";

  // reference model state
  int mMem [4096];
  int mShift = 0, mRow = 0, mCode = 0;
  bit mDim = 0;

  always #10 clk = ~clk;   // 50 MHz

  txvSerializer u0 (
    .clk(clk), .rstN(rstN), .charByte(charByte), .lineNum(lineNum),
    .altSet(altSet), .showNull(showNull), .loadPulse(loadPulse),
    .glyphWrEn(glyphWrEn), .glyphWrSet(glyphWrSet),
    .glyphWrCode(glyphWrCode), .glyphWrLine(glyphWrLine),
    .glyphWrData(glyphWrData), .videoBit(videoBit), .dimOut(dimOut)
  );

  function automatic int addrOf(int s, int c, int l);
    return (s << 11) | ((c & 127) << 4) | (l & 15);
  endfunction

  function automatic int patOf(int s, int c, int l);
    return (c * 37 + l * 91 + s * 113 + 5) & 255;
  endfunction

  // behavioural model: one step per clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mShift = 0; mDim = 0; mCode = 0; mRow = 0;
    end else begin
      if (loadPulse) begin
        mShift = (((mCode & 127) == 0) && !showNull) ? 0 : mRow;
        mDim   = mCode[7];
      end else begin
        mShift = (mShift << 1) & 255;
      end
      mRow  = mMem[addrOf(int'(altSet), int'(charByte), int'(lineNum))];
      mCode = int'(charByte);
      if (glyphWrEn)
        mMem[addrOf(int'(glyphWrSet), int'(glyphWrCode), int'(glyphWrLine))] = int'(glyphWrData);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (videoBit !== mShift[7] || dimOut !== mDim) begin
        bad++;
        $display("FAIL %s: video=%b dim=%b expected video=%b dim=%b",
                 curReq, videoBit, dimOut, mShift[7], mDim);
      end
    end
  end

  task automatic cellShow(input int code, input int line, input bit alt, input bit shn);
    charByte = 8'(code); lineNum = 4'(line); altSet = alt; showNull = shn;
    loadPulse = 1'b0;
    @(negedge clk);
    loadPulse = 1'b1;
    @(negedge clk);
    loadPulse = 1'b0;
    charByte = 8'((code * 3 + 17) & 255);   // inputs may move during shift-out
    repeat (6) @(negedge clk);
  endtask

  task automatic glyphWrite(input int s, input int c, input int l, input int d);
    glyphWrEn = 1'b1; glyphWrSet = 1'(s); glyphWrCode = 7'(c);
    glyphWrLine = 4'(l); glyphWrData = 8'(d);
    @(negedge clk);
    glyphWrEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mMem[i] = 0;
    curReq = "R9";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);   // R9: no load yet, outputs stay dark
    curReq = "R10";
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 128; c++)
        for (int l = 0; l < 16; l++)
          glyphWrite(s, c, l, patOf(s, c, l));
    glyphWrite(0, 0, 3, 8'hA5);
    glyphWrite(1, 0, 3, 8'h3C);
    curReq = "R1";
    for (int k = 0; k < 40; k++) cellShow((k * 13 + 1) & 127, k & 15, 1'b0, 1'b0);
    curReq = "R2";
    for (int k = 0; k < 40; k++) cellShow((k * 29 + 2) & 127, (k * 5) & 15, k[0], 1'b0);
    curReq = "R3";
    cellShow(65, 7, 1'b0, 1'b0);
    cellShow(127, 15, 1'b1, 1'b0);
    curReq = "R4";
    cellShow(90, 2, 1'b0, 1'b0);
    loadPulse = 1'b0;
    repeat (12) @(negedge clk);   // drained row stays dark
    curReq = "R5";
    cellShow(0, 3, 1'b0, 1'b0);
    cellShow(0, 3, 1'b1, 1'b0);
    cellShow(128, 3, 1'b0, 1'b0);
    curReq = "R6";
    cellShow(0, 3, 1'b0, 1'b1);
    cellShow(0, 3, 1'b1, 1'b1);
    cellShow(48, 3, 1'b0, 1'b1);
    curReq = "R7";
    for (int k = 0; k < 16; k++) cellShow(((k * 11) & 127) | ((k & 1) << 7), k, 1'b0, 1'b0);
    curReq = "R8";
    for (int k = 0; k < 8; k++) begin
      cellShow(33 + k, k, 1'b1, 1'b0);
      cellShow(161 + k, k, 1'b1, 1'b0);
    end
    curReq = "R10";
    glyphWrite(0, 66, 4, 8'h81);
    cellShow(66, 4, 1'b0, 1'b0);
    glyphWrite(1, 66, 4, 8'h7E);
    cellShow(66, 4, 1'b1, 1'b0);
    cellShow(66, 4, 1'b0, 1'b0);
    curReq = "R9";
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog %s: run did not finish, expected completion", curReq);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule